// File: doc/BRIEF.md
# ECC Memory Controller Register Block

This block holds the control and status registers of an ECC memory controller. Nine 32-bit registers sit behind a single-cycle register bus and are selected by the word index (byte address shifted right by two). The register set covers controller enable, timing delay, fault status, video configuration, two fault address words, a diagnostic word and two event counters. Byte address bits 1:0 do not take part in the decode, because the main window only carries full-word accesses.

A `VARIANT` parameter selects one of three controller flavours. The variant sets which enable-register bits software may write. It also sets the identity value held in the top byte of the enable register, and which enable bits survive a warm reset. Only the base variant (0) has a 4-byte diagnostic window with byte access. The fault status and fault address registers take their values from a capture port, which stands in for the memory datapath. A captured correctable error raises a level interrupt when interrupts are enabled. Any bus write to fault status lowers that interrupt.

Bus writes take effect at the rising clock edge. Read data is combinational from the current register state while a read is presented. `rst_ni` is the power-on reset. `soft_rst_i` is a synchronous warm reset that keeps selected enable bits.

Top module: `ecc_ctl_regs`

## Requirements
- R1: Word index 0..8 selects enable, delay, fault status, video config, fault address 0, fault address 1, diagnostic, event count 0, event count 1; a read at index 9..15 returns 0 and a write there changes no register.
- R2: For VARIANT 0, an enable write stores wdata & 0x103. For VARIANT 0x10000000 or 0x20000000 it stores VARIANT | (wdata & 0xBFF), so bits 31:24 always read VARIANT[31:24].
- R3: After power-on reset the registers hold the following values: enable = VARIANT, delay = 0x20, fault address 0 = 0x07C00000, all other registers 0. The interrupt is low and every diagnostic byte is 0.
- R4: A delay write stores wdata & 0x7FFFFFFF, so bit 31 always reads 0.
- R5: A bus write to fault status stores the full written value and drives irq_o low on the next cycle, unless a capture occurs in the same cycle.
- R6: Fault address 0 and 1 ignore bus writes. A capture (cap_valid_i high at an edge) loads fault status, fault address 0 and fault address 1 from the capture inputs. A capture in the same cycle as a bus write to fault status takes priority.
- R7: irq_o rises the cycle after a capture only if enable bit 1 is set and captured status bit 0 (correctable error) is set. Otherwise a capture leaves irq_o unchanged.
- R8: A warm reset keeps only enable bits 0x100 for VARIANT 0, or bits 0xFF000BFC for the other variants. It loads delay 0x20 and fault address 0 0x07C00000, clears every other register and all diagnostic bytes, and drives irq_o low.
- R9: Video config, diagnostic and both event count registers store all 32 bits. Event count 0 and 1 are separate registers.
- R10: With VARIANT 0, the diagnostic window holds 4 bytes indexed by diag_addr_i[1:0] for both read and write. With any other VARIANT, diag_rdata_o is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| soft_rst_i | input | 1 | Synchronous warm reset |
| req_i | input | 1 | Register bus access strobe |
| we_i | input | 1 | Register bus write (1) or read (0) |
| addr_i | input | AW | Register bus byte address |
| wdata_i | input | 32 | Register bus write data |
| rdata_o | output | 32 | Register bus read data (0 when no read) |
| diag_req_i | input | 1 | Diagnostic window access strobe |
| diag_we_i | input | 1 | Diagnostic window write (1) or read (0) |
| diag_addr_i | input | DAW | Diagnostic byte index |
| diag_wdata_i | input | 8 | Diagnostic write byte |
| diag_rdata_o | output | 8 | Diagnostic read byte |
| cap_valid_i | input | 1 | Fault capture strobe |
| cap_status_i | input | 32 | Captured fault status |
| cap_addr0_i | input | 32 | Captured fault address word 0 |
| cap_addr1_i | input | 32 | Captured fault address word 1 |
| irq_o | output | 1 | Level interrupt for correctable errors |

## Verification
The bench drives two instances together, one of the base variant and one extended variant. This exposes a write mask or warm-reset keep mask applied for the wrong variant: the enable readback then differs in bits 11, 9:2 or 31:24. It writes event count 1 and then reads event count 0, which catches an aliased counter index. It also writes the read-only fault address words, which catches a decode that lets bus writes land there. Captures are run with the correctable bit clear, with interrupts disabled, and in the same cycle as a fault status write. A wrong gate or a wrong priority then shows up as a stray interrupt or as lost capture data. A warm reset is applied while the interrupt is pending and registers are dirty, which catches a design that clears kept enable bits or leaves the interrupt or the diagnostic bytes set.

// File: rtl/ecc_ctl_pkg.sv
package ecc_ctl_pkg;
  parameter int unsigned DW      = 32;
  parameter int unsigned DIAG_BW = 8;
  parameter int unsigned NREG    = 9;

  // Word index order is decoded by software; keep it fixed.
  localparam int unsigned IDX_EN   = 0;
  localparam int unsigned IDX_DLY  = 1;
  localparam int unsigned IDX_FST  = 2;
  localparam int unsigned IDX_VID  = 3;
  localparam int unsigned IDX_FA0  = 4;
  localparam int unsigned IDX_FA1  = 5;
  localparam int unsigned IDX_DIAG = 6;
  localparam int unsigned IDX_EV0  = 7;
  localparam int unsigned IDX_EV1  = 8;

  localparam logic [DW-1:0] EN_WMASK_BASE = 32'h0000_0103;
  localparam logic [DW-1:0] EN_WMASK_EXT  = 32'h0000_0BFF;
  localparam logic [DW-1:0] EN_KEEP_BASE  = 32'h0000_0100;
  localparam logic [DW-1:0] EN_KEEP_EXT   = 32'hFF00_0BFC;
  localparam logic [DW-1:0] DLY_WMASK     = 32'h7FFF_FFFF;
  localparam logic [DW-1:0] DLY_RST       = 32'h0000_0020;
  localparam logic [DW-1:0] FA0_RST       = 32'h07C0_0000;

  localparam int unsigned EN_IRQ_BIT = 1;
  localparam int unsigned FST_CE_BIT = 0;

  function automatic logic [DW-1:0] en_wr_value(input logic [DW-1:0] variant,
                                                input logic [DW-1:0] wdata);
    if (variant == '0) return wdata & EN_WMASK_BASE;
    return variant | (wdata & EN_WMASK_EXT);
  endfunction

  function automatic logic [DW-1:0] en_keep_mask(input logic [DW-1:0] variant);
    return (variant == '0) ? EN_KEEP_BASE : EN_KEEP_EXT;
  endfunction
endpackage

// File: rtl/ecc_ctl_decode.sv
module ecc_ctl_decode
  import ecc_ctl_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  output logic [NREG-1:0] wr_sel_o,
  output logic [NREG-1:0] rd_sel_o
);
  localparam int unsigned IW = AW - 2;

  logic [IW-1:0] idx;
  logic          unused_byte_lane;

  assign idx              = addr_i[AW-1:2];
  assign unused_byte_lane = ^addr_i[1:0];

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    localparam logic [IW-1:0] SEL_IDX = IW'(g);
    assign wr_sel_o[g] = req_i &  we_i & (idx == SEL_IDX);
    assign rd_sel_o[g] = req_i & ~we_i & (idx == SEL_IDX);
  end
endmodule

// File: rtl/ecc_ctl_fault.sv
module ecc_ctl_fault
  import ecc_ctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          fst_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          irq_en_i,
  input  logic          cap_valid_i,
  input  logic [DW-1:0] cap_status_i,
  input  logic [DW-1:0] cap_addr0_i,
  input  logic [DW-1:0] cap_addr1_i,
  output logic [DW-1:0] fst_o,
  output logic [DW-1:0] fa0_o,
  output logic [DW-1:0] fa1_o,
  output logic          irq_o
);
  logic [DW-1:0] fst_q, fa0_q, fa1_q;
  logic          irq_q;
  logic          ce_hit;

  assign ce_hit = irq_en_i & cap_status_i[FST_CE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fst_q <= '0;
      fa0_q <= FA0_RST;
      fa1_q <= '0;
      irq_q <= 1'b0;
    end else if (soft_rst_i) begin
      fst_q <= '0;
      fa0_q <= FA0_RST;
      fa1_q <= '0;
      irq_q <= 1'b0;
    end else if (cap_valid_i) begin
      // capture outranks a same-cycle status write so no fault is lost
      fst_q <= cap_status_i;
      fa0_q <= cap_addr0_i;
      fa1_q <= cap_addr1_i;
      irq_q <= irq_q | ce_hit;
    end else if (fst_wr_i) begin
      fst_q <= wdata_i;
      irq_q <= 1'b0;
    end
  end

  assign fst_o = fst_q;
  assign fa0_o = fa0_q;
  assign fa1_o = fa1_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/ecc_ctl_diag.sv
module ecc_ctl_diag #(
  parameter bit          PRESENT = 1'b1,
  parameter int unsigned DAW     = 2,
  parameter int unsigned BW      = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           soft_rst_i,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [DAW-1:0] addr_i,
  input  logic [BW-1:0]  wdata_i,
  output logic [BW-1:0]  rdata_o
);
  localparam int unsigned NB = 1 << DAW;

  if (PRESENT) begin : g_win
    logic [BW-1:0] mem_q [NB];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < NB; i++) mem_q[i] <= '0;
      end else if (soft_rst_i) begin
        for (int i = 0; i < NB; i++) mem_q[i] <= '0;
      end else if (req_i && we_i) begin
        mem_q[addr_i] <= wdata_i;
      end
    end

    assign rdata_o = (req_i && !we_i) ? mem_q[addr_i] : '0;
  end else begin : g_none
    logic unused_diag;
    assign unused_diag = ^{clk_i, rst_ni, soft_rst_i, req_i, we_i, addr_i, wdata_i};
    assign rdata_o     = '0;
  end
endmodule

// File: rtl/ecc_ctl_regs.sv
module ecc_ctl_regs
  import ecc_ctl_pkg::*;
#(
  parameter logic [31:0] VARIANT = 32'h0000_0000,
  parameter int unsigned AW      = 6,
  parameter int unsigned DAW     = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic               diag_req_i,
  input  logic               diag_we_i,
  input  logic [DAW-1:0]     diag_addr_i,
  input  logic [DIAG_BW-1:0] diag_wdata_i,
  output logic [DIAG_BW-1:0] diag_rdata_o,
  input  logic               cap_valid_i,
  input  logic [DW-1:0]      cap_status_i,
  input  logic [DW-1:0]      cap_addr0_i,
  input  logic [DW-1:0]      cap_addr1_i,
  output logic               irq_o
);
  localparam logic [DW-1:0] EN_KEEP      = en_keep_mask(VARIANT);
  localparam bit            DIAG_PRESENT = (VARIANT == '0);

  logic [NREG-1:0] wr_sel, rd_sel;
  logic [DW-1:0]   en_q, dly_q, vid_q, dr_q, ev0_q, ev1_q;
  logic [DW-1:0]   fst, fa0, fa1;
  logic [DW-1:0]   rd_val [NREG];

  ecc_ctl_decode #(.AW(AW)) u_decode (
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wr_sel_o(wr_sel),
    .rd_sel_o(rd_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= VARIANT;
      dly_q <= DLY_RST;
      vid_q <= '0;
      dr_q  <= '0;
      ev0_q <= '0;
      ev1_q <= '0;
    end else if (soft_rst_i) begin
      en_q  <= en_q & EN_KEEP;
      dly_q <= DLY_RST;
      vid_q <= '0;
      dr_q  <= '0;
      ev0_q <= '0;
      ev1_q <= '0;
    end else begin
      if (wr_sel[IDX_EN])   en_q  <= en_wr_value(VARIANT, wdata_i);
      if (wr_sel[IDX_DLY])  dly_q <= wdata_i & DLY_WMASK;
      if (wr_sel[IDX_VID])  vid_q <= wdata_i;
      if (wr_sel[IDX_DIAG]) dr_q  <= wdata_i;
      if (wr_sel[IDX_EV0])  ev0_q <= wdata_i;
      if (wr_sel[IDX_EV1])  ev1_q <= wdata_i;
    end
  end

  ecc_ctl_fault u_fault (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .fst_wr_i    (wr_sel[IDX_FST]),
    .wdata_i     (wdata_i),
    .irq_en_i    (en_q[EN_IRQ_BIT]),
    .cap_valid_i (cap_valid_i),
    .cap_status_i(cap_status_i),
    .cap_addr0_i (cap_addr0_i),
    .cap_addr1_i (cap_addr1_i),
    .fst_o       (fst),
    .fa0_o       (fa0),
    .fa1_o       (fa1),
    .irq_o       (irq_o)
  );

  ecc_ctl_diag #(.PRESENT(DIAG_PRESENT), .DAW(DAW), .BW(DIAG_BW)) u_diag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst_i),
    .req_i     (diag_req_i),
    .we_i      (diag_we_i),
    .addr_i    (diag_addr_i),
    .wdata_i   (diag_wdata_i),
    .rdata_o   (diag_rdata_o)
  );

  assign rd_val[IDX_EN]   = en_q;
  assign rd_val[IDX_DLY]  = dly_q;
  assign rd_val[IDX_FST]  = fst;
  assign rd_val[IDX_VID]  = vid_q;
  assign rd_val[IDX_FA0]  = fa0;
  assign rd_val[IDX_FA1]  = fa1;
  assign rd_val[IDX_DIAG] = dr_q;
  assign rd_val[IDX_EV0]  = ev0_q;
  assign rd_val[IDX_EV1]  = ev1_q;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_sel[i]) rdata_o = rdata_o | rd_val[i];
    end
  end
endmodule

// File: rtl/ecc_ctl_regs_chk.sv
module ecc_ctl_regs_chk
  import ecc_ctl_pkg::*;
#(
  parameter logic [31:0] VARIANT = 32'h0000_0000,
  parameter int unsigned AW      = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          soft_rst_i,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] rdata_o,
  input logic          cap_valid_i,
  input logic [DW-1:0] cap_status_i,
  input logic [DW-1:0] en_q,
  input logic          irq_o
);
  logic rd_any;
  logic [AW-3:0] idx;
  assign rd_any = req_i && !we_i;
  assign idx    = addr_i[AW-1:2];

  p_unmapped_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_any && int'(idx) >= NREG) |-> (rdata_o == '0));

  p_identity_byte_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_any && int'(idx) == IDX_EN) |-> (rdata_o[31:24] == VARIANT[31:24]));

  p_dly_msb_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_any && int'(idx) == IDX_DLY) |-> !rdata_o[31]);

  p_fst_wr_drops_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && int'(idx) == IDX_FST && !cap_valid_i) |=> !irq_o);

  p_irq_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(cap_valid_i && cap_status_i[FST_CE_BIT] && en_q[EN_IRQ_BIT]));

  p_warm_rst_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !irq_o);
endmodule

bind ecc_ctl_regs ecc_ctl_regs_chk #(.VARIANT(VARIANT), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .soft_rst_i  (soft_rst_i),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .rdata_o     (rdata_o),
  .cap_valid_i (cap_valid_i),
  .cap_status_i(cap_status_i),
  .en_q        (en_q),
  .irq_o       (irq_o)
);

// File: tb/ecc_ctl_regs_tb_top.sv
module ecc_ctl_regs_tb_top;
  localparam logic [31:0] VAR_B = 32'h1000_0000;
  localparam int unsigned AW    = 6;
  localparam int unsigned NVEC  = 11;

  typedef struct packed {
    logic [7:0]  req;
    logic [3:0]  idx;
    logic [31:0] wdata;
    logic [31:0] exp_a;
    logic [31:0] exp_b;
  } vec_t;

  // write then read back; a = base variant, b = extended variant
  localparam vec_t VECS [NVEC] = '{
    '{8'd2, 4'd0, 32'hFFFF_FFFF, 32'h0000_0103, 32'h1000_0BFF}, // R2
    '{8'd4, 4'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF}, // R4
    '{8'd9, 4'd3, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 32'hA5A5_A5A5}, // R9
    '{8'd9, 4'd6, 32'h1234_5678, 32'h1234_5678, 32'h1234_5678}, // R9
    '{8'd9, 4'd7, 32'h1111_2222, 32'h1111_2222, 32'h1111_2222}, // R9
    '{8'd9, 4'd8, 32'h3333_4444, 32'h3333_4444, 32'h3333_4444}, // R9
    '{8'd6, 4'd4, 32'hDEAD_BEEF, 32'h07C0_0000, 32'h07C0_0000}, // R6
    '{8'd6, 4'd5, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000}, // R6
    '{8'd1, 4'd9, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000}, // R1
    '{8'd5, 4'd2, 32'h0001_FF09, 32'h0001_FF09, 32'h0001_FF09}, // R5
    '{8'd2, 4'd0, 32'h0000_0000, 32'h0000_0000, 32'h1000_0000}  // R2
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        soft_rst = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        dreq = 1'b0, dwe = 1'b0;
  logic [1:0]  daddr = '0;
  logic [7:0]  dwdata = '0;
  logic [7:0]  drdata_a, drdata_b;
  logic        cap_valid = 1'b0;
  logic [31:0] cap_status = '0, cap_a0 = '0, cap_a1 = '0;
  logic        irq_a, irq_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ecc_ctl_regs #(.VARIANT(32'h0), .AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_a),
    .diag_req_i(dreq), .diag_we_i(dwe), .diag_addr_i(daddr),
    .diag_wdata_i(dwdata), .diag_rdata_o(drdata_a),
    .cap_valid_i(cap_valid), .cap_status_i(cap_status),
    .cap_addr0_i(cap_a0), .cap_addr1_i(cap_a1), .irq_o(irq_a)
  );

  ecc_ctl_regs #(.VARIANT(VAR_B), .AW(AW)) dut_b_i (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_b),
    .diag_req_i(dreq), .diag_we_i(dwe), .diag_addr_i(daddr),
    .diag_wdata_i(dwdata), .diag_rdata_o(drdata_b),
    .cap_valid_i(cap_valid), .cap_status_i(cap_status),
    .cap_addr0_i(cap_a0), .cap_addr1_i(cap_a1), .irq_o(irq_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(idx * 4); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] a, output logic [31:0] b);
    req = 1'b1; we = 1'b0; addr = AW'(idx * 4);
    #1;
    a = rdata_a; b = rdata_b;
    req = 1'b0;
  endtask

  task automatic chk_both(input string tag, input int idx,
                          input logic [31:0] ea, input logic [31:0] eb);
    logic [31:0] a, b;
    rd(idx, a, b);
    chk({tag, " base"}, a, ea);
    chk({tag, " ext"}, b, eb);
  endtask

  task automatic dwr(input int idx, input logic [7:0] d);
    @(negedge clk);
    dreq = 1'b1; dwe = 1'b1; daddr = 2'(idx); dwdata = d;
    @(negedge clk);
    dreq = 1'b0; dwe = 1'b0;
  endtask

  task automatic dchk(input string tag, input int idx, input logic [7:0] ea);
    dreq = 1'b1; dwe = 1'b0; daddr = 2'(idx);
    #1;
    chk({tag, " base"}, 32'(drdata_a), 32'(ea));
    chk({tag, " ext"}, 32'(drdata_b), 32'h0);
    dreq = 1'b0;
  endtask

  task automatic capture(input logic [31:0] st, input logic [31:0] a0, input logic [31:0] a1);
    @(negedge clk);
    cap_valid = 1'b1; cap_status = st; cap_a0 = a0; cap_a1 = a1;
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  task automatic chk_irq(input string tag, input logic e);
    chk({tag, " irq base"}, 32'(irq_a), 32'(e));
    chk({tag, " irq ext"}, 32'(irq_b), 32'(e));
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R3 power-on state
    chk_both("R3 enable", 0, 32'h0, VAR_B);
    chk_both("R3 delay", 1, 32'h20, 32'h20);
    chk_both("R3 fault status", 2, 32'h0, 32'h0);
    chk_both("R3 fault addr0", 4, 32'h07C0_0000, 32'h07C0_0000);
    chk_both("R3 event1", 8, 32'h0, 32'h0);
    chk_irq("R3", 1'b0);
    dchk("R3 diag", 3, 8'h00);

    for (int k = 0; k < NVEC; k++) begin
      wr(int'(VECS[k].idx), VECS[k].wdata);
      rd(int'(VECS[k].idx), a, b);
      chk($sformatf("R%0d vector %0d base", VECS[k].req, k), a, VECS[k].exp_a);
      chk($sformatf("R%0d vector %0d ext", VECS[k].req, k), b, VECS[k].exp_b);
    end

    // R9 event counters independent; R1 unmapped write touched nothing
    chk_both("R9 event0 after event1 write", 7, 32'h1111_2222, 32'h1111_2222);
    chk_both("R1 unmapped index 15", 15, 32'h0, 32'h0);
    chk_both("R1 video intact", 3, 32'hA5A5_A5A5, 32'hA5A5_A5A5);

    // R6 / R7 capture with interrupts enabled
    wr(0, 32'h2);
    capture(32'h0000_AB01, 32'h0000_1234, 32'h0000_5678);
    chk_irq("R7 ce capture", 1'b1);
    chk_both("R6 status captured", 2, 32'h0000_AB01, 32'h0000_AB01);
    chk_both("R6 addr0 captured", 4, 32'h0000_1234, 32'h0000_1234);
    chk_both("R6 addr1 captured", 5, 32'h0000_5678, 32'h0000_5678);

    wr(2, 32'h0);
    chk_irq("R5 status write", 1'b0);

    capture(32'h0000_0008, 32'h1, 32'h2);
    chk_irq("R7 no ce bit", 1'b0);

    wr(0, 32'h0);
    capture(32'h0000_0001, 32'h3, 32'h4);
    chk_irq("R7 irq disabled", 1'b0);

    // R6 capture beats same-cycle status write
    wr(0, 32'h2);
    @(negedge clk);
    cap_valid = 1'b1; cap_status = 32'h0000_0001; cap_a0 = 32'h55; cap_a1 = 32'h66;
    req = 1'b1; we = 1'b1; addr = AW'(2 * 4); wdata = 32'hFFFF_0000;
    @(negedge clk);
    cap_valid = 1'b0; req = 1'b0; we = 1'b0;
    chk_irq("R7 capture over write", 1'b1);
    chk_both("R6 capture over write", 2, 32'h1, 32'h1);

    // R10 diagnostic window
    dwr(2, 8'h5A);
    dwr(1, 8'hC3);
    dchk("R10 diag byte2", 2, 8'h5A);
    dchk("R10 diag byte1", 1, 8'hC3);
    dchk("R10 diag byte0", 0, 8'h00);

    // R8 warm reset with dirty state and pending irq
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'h5);
    wr(3, 32'h7);
    wr(8, 32'h9);
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk_both("R8 enable kept", 0, 32'h0000_0100, 32'h1000_0BFC);
    chk_both("R8 delay", 1, 32'h20, 32'h20);
    chk_both("R8 video", 3, 32'h0, 32'h0);
    chk_both("R8 fault addr0", 4, 32'h07C0_0000, 32'h07C0_0000);
    chk_both("R8 fault status", 2, 32'h0, 32'h0);
    chk_both("R8 event1", 8, 32'h0, 32'h0);
    chk_irq("R8", 1'b0);
    dchk("R8 diag cleared", 1, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule